// File: doc/BRIEF.md
# Frame Header Finder and Tracker

This block takes one digitised sample per clock from each of several readout channels and works out, from the data alone, where frames begin. The first channel is the master. Its samples are compared with a programmable threshold. The resulting high/low stream is used to tell short idle pulses apart from frame headers. The idle front-end chips emit a short pulse every 70 clocks. The block follows that pulse train to gain and keep lock. A frame is accepted only while locked.

When a high run on the master reaches the programmed header length inside the idle period, the block starts a frame. It then emits one strobe per payload sample, with a running index and the registered samples of every channel. The remaining channels are assumed to be aligned with the master, so they are captured on the master's timing. Each channel's sample at the last header position is also held as a header-height figure, which is used for gain normalisation.

Top module: `frame_header_tracker`

## Requirements
- R1: A master sample is high only when it is strictly greater than `thresh_i`; a header made of samples equal to or below the threshold starts no frame.
- R2: A pulse is a run of high master samples shorter than `hdr_len_i`, and it takes effect on the first low sample after the run. `locked_o` rises in the cycle after the third pulse in a chain where each pulse ends exactly 70 cycles after the one before.
- R3: When locked, if no pulse ends at the 70th cycle after the previous one, `locked_o` falls.
- R4: A pulse that ends at any other spacing clears `locked_o`. It also becomes the first pulse of a new chain, so two more pulses at the correct spacing restore lock.
- R5: A run of high master samples reaching `hdr_len_i` starts a frame only while locked, outside a frame and before the next pulse is due. While unlocked, such a run is ignored.
- R6: The sample after the last header sample is payload index 0. `sample_valid_o` is high for PAYLOAD_LEN consecutive cycles with `sample_index_o` counting 0 to PAYLOAD_LEN-1, and `frame_start_o` is high only with index 0. Each output appears one clock after the sample it reports.
- R7: With each valid strobe, `samples_o` carries every channel's sample for that payload position. Channel k occupies bits [k*SAMPLE_W +: SAMPLE_W].
- R8: `hdr_height_o` holds each channel's sample at the last header sample, unchanged until the next accepted header.
- R9: Inside a frame, master samples are not examined for pulses or headers, and `locked_o` does not change.
- R10: After a frame, the first pulse that ends re-anchors the 70-cycle period and keeps lock. If no pulse ends within 70 cycles of the last payload sample, lock is dropped.
- R11: After reset, `locked_o`, `sample_valid_o` and `frame_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thresh_i | input | SAMPLE_W | Digital-high threshold for master samples |
| hdr_len_i | input | HDR_W | Header run length, at least 2 |
| samples_i | input | NUM_CH*SAMPLE_W | One sample per channel, channel 0 is master |
| locked_o | output | 1 | Pulse train tracked |
| frame_start_o | output | 1 | First payload sample of a frame |
| sample_valid_o | output | 1 | Payload sample strobe |
| sample_index_o | output | IDX_W | Payload index |
| samples_o | output | NUM_CH*SAMPLE_W | Registered payload samples, all channels |
| hdr_height_o | output | NUM_CH*SAMPLE_W | Per-channel header sample |

## Verification
The main function is driven with header runs of several lengths and amplitudes while locked. Amplitudes just above the threshold, equal to it and well below it separate the strict comparison from a non-strict one. Header lengths of 3, 4 and 6 show that the run length comes from the input rather than a constant. Pulse trains with correct spacing, one cycle late, early, and missing after a frame show which spacing errors drop lock and how a new chain is counted. Payload values that cross the threshold during a frame show whether detection stays suspended.

// File: rtl/fhf_pkg.sv
`timescale 1ns/1ps
package fhf_pkg;
  // events decoded from the master channel run counter
  typedef struct packed {
    logic header;  // run just reached the programmed header length
    logic marker;  // short run ended on this sample
  } run_evt_t;
endpackage

// File: rtl/fhf_run_detect.sv
`timescale 1ns/1ps
module fhf_run_detect
  import fhf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int HDR_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic [HDR_W-1:0]    hdr_len_i,
  input  logic                hold_i,
  output run_evt_t            evt_o
);
  localparam logic [HDR_W-1:0] RUN_MAX = {HDR_W{1'b1}};

  logic             hi;
  logic [HDR_W-1:0] run_q, run_d;

  always_comb begin
    hi           = sample_i > thresh_i;
    evt_o.header = hi && (({1'b0, run_q} + (HDR_W+1)'(1)) == {1'b0, hdr_len_i});
    evt_o.marker = !hi && (run_q != '0) && (run_q < hdr_len_i);
    if (hold_i || !hi)          run_d = '0;
    else if (run_q != RUN_MAX)  run_d = run_q + 1'b1;
    else                        run_d = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  // R2
  marker_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.marker |-> ($past(sample_i) > $past(thresh_i)));
endmodule

// File: rtl/fhf_lock_tracker.sv
`timescale 1ns/1ps
module fhf_lock_tracker #(
  parameter int IDLE_PERIOD = 70,
  parameter int LOCK_COUNT  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic marker_evt_i,
  input  logic header_cand_i,
  input  logic in_frame_i,
  input  logic frame_end_i,
  output logic locked_o,
  output logic hdr_accept_o
);
  localparam int MK_W = $clog2(IDLE_PERIOD + 2);
  localparam int ST_W = $clog2(LOCK_COUNT + 1);
  localparam logic [MK_W-1:0] DUE  = MK_W'(IDLE_PERIOD);
  localparam logic [MK_W-1:0] LATE = MK_W'(IDLE_PERIOD + 1);

  logic [MK_W-1:0] since_q, since_d;
  logic [ST_W-1:0] streak_q, streak_d;
  logic            locked_q, locked_d;
  logic            trail_q, trail_d;
  logic            due;

  always_comb begin
    since_d  = since_q;
    streak_d = streak_q;
    locked_d = locked_q;
    trail_d  = trail_q;
    due      = since_q == DUE;
    if (frame_end_i) begin
      since_d = MK_W'(1);
      trail_d = 1'b1;
    end else if (in_frame_i) begin
      since_d = since_q;
    end else if (marker_evt_i) begin
      since_d = MK_W'(1);
      if (trail_q) begin
        trail_d = 1'b0;
      end else if (streak_q != '0 && due) begin
        streak_d = (streak_q == ST_W'(LOCK_COUNT)) ? streak_q : streak_q + 1'b1;
        locked_d = ({1'b0, streak_q} + (ST_W+1)'(1)) >= (ST_W+1)'(LOCK_COUNT);
      end else begin
        streak_d = ST_W'(1);
        locked_d = (LOCK_COUNT == 1);
      end
    end else if (due && (streak_q != '0 || trail_q)) begin
      streak_d = '0;
      locked_d = 1'b0;
      trail_d  = 1'b0;
      since_d  = LATE;
    end else if (since_q != LATE) begin
      since_d = since_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q  <= '0;
      streak_q <= '0;
      locked_q <= 1'b0;
      trail_q  <= 1'b0;
    end else begin
      since_q  <= since_d;
      streak_q <= streak_d;
      locked_q <= locked_d;
      trail_q  <= trail_d;
    end
  end

  assign locked_o     = locked_q;
  assign hdr_accept_o = header_cand_i && locked_q && !in_frame_i && !trail_q && (since_q < DUE);

  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(marker_evt_i));
  // R9
  frame_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_i |=> $stable(locked_q));
  // R3
  lock_loss_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> ($past(marker_evt_i) || $past(since_q) == DUE));
endmodule

// File: rtl/fhf_frame_seq.sv
`timescale 1ns/1ps
module fhf_frame_seq #(
  parameter int PAYLOAD_LEN = 256,
  localparam int IDX_W      = $clog2(PAYLOAD_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_accept_i,
  output logic             in_frame_o,
  output logic             frame_end_o,
  output logic             valid_o,
  output logic             start_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAYLOAD_LEN - 1);

  logic             in_frame_q, in_frame_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_out_q, idx_out_d;
  logic             valid_q, valid_d, start_q, start_d;

  always_comb begin
    in_frame_d = in_frame_q;
    idx_d      = idx_q;
    valid_d    = in_frame_q;
    start_d    = in_frame_q && (idx_q == '0);
    idx_out_d  = in_frame_q ? idx_q : idx_out_q;
    if (hdr_accept_i) begin
      in_frame_d = 1'b1;
      idx_d      = '0;
    end else if (in_frame_q) begin
      if (idx_q == LAST) begin
        in_frame_d = 1'b0;
        idx_d      = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
      idx_out_q  <= '0;
      valid_q    <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      idx_q      <= idx_d;
      idx_out_q  <= idx_out_d;
      valid_q    <= valid_d;
      start_q    <= start_d;
    end
  end

  assign in_frame_o  = in_frame_q;
  assign frame_end_o = in_frame_q && (idx_q == LAST);
  assign valid_o     = valid_q;
  assign start_o     = start_q;
  assign idx_o       = idx_out_q;

  // R5
  accept_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_accept_i |=> (in_frame_q && idx_q == '0));
  // R6
  start_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (valid_q && idx_out_q == '0));
  // R6
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && idx_out_q != LAST) |=> (valid_q && idx_out_q == $past(idx_out_q) + 1'b1));
  // R6
  last_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && idx_out_q == LAST) |=> !valid_q);
endmodule

// File: rtl/fhf_chan_capture.sv
`timescale 1ns/1ps
module fhf_chan_capture #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                cap_payload_i,
  input  logic                cap_header_i,
  output logic [SAMPLE_W-1:0] payload_o,
  output logic [SAMPLE_W-1:0] height_o
);
  logic [SAMPLE_W-1:0] pay_q, pay_d, hgt_q, hgt_d;

  always_comb begin
    pay_d = cap_payload_i ? sample_i : pay_q;
    hgt_d = cap_header_i  ? sample_i : hgt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_q <= '0;
      hgt_q <= '0;
    end else begin
      pay_q <= pay_d;
      hgt_q <= hgt_d;
    end
  end

  assign payload_o = pay_q;
  assign height_o  = hgt_q;

  // R8
  height_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_header_i |=> $stable(hgt_q));
endmodule

// File: rtl/frame_header_tracker.sv
`timescale 1ns/1ps
module frame_header_tracker
  import fhf_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SAMPLE_W    = 10,
  parameter int HDR_W       = 4,
  parameter int IDLE_PERIOD = 70,
  parameter int LOCK_COUNT  = 3,
  parameter int PAYLOAD_LEN = 256,
  localparam int IDX_W      = $clog2(PAYLOAD_LEN),
  localparam int BUS_W      = NUM_CH * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic [HDR_W-1:0]    hdr_len_i,
  input  logic [BUS_W-1:0]    samples_i,
  output logic                locked_o,
  output logic                frame_start_o,
  output logic                sample_valid_o,
  output logic [IDX_W-1:0]    sample_index_o,
  output logic [BUS_W-1:0]    samples_o,
  output logic [BUS_W-1:0]    hdr_height_o
);
  logic     rst_meta_q, rst_sync_q;
  run_evt_t evt;
  logic     in_frame, frame_end, hdr_accept, hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign hold = in_frame || hdr_accept;

  fhf_run_detect #(.SAMPLE_W(SAMPLE_W), .HDR_W(HDR_W)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .sample_i  (samples_i[SAMPLE_W-1:0]),
    .thresh_i  (thresh_i),
    .hdr_len_i (hdr_len_i),
    .hold_i    (hold),
    .evt_o     (evt)
  );

  fhf_lock_tracker #(.IDLE_PERIOD(IDLE_PERIOD), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_q),
    .marker_evt_i  (evt.marker),
    .header_cand_i (evt.header),
    .in_frame_i    (in_frame),
    .frame_end_i   (frame_end),
    .locked_o      (locked_o),
    .hdr_accept_o  (hdr_accept)
  );

  fhf_frame_seq #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_q),
    .hdr_accept_i (hdr_accept),
    .in_frame_o   (in_frame),
    .frame_end_o  (frame_end),
    .valid_o      (sample_valid_o),
    .start_o      (frame_start_o),
    .idx_o        (sample_index_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fhf_chan_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
      .clk_i         (clk_i),
      .rst_ni        (rst_sync_q),
      .sample_i      (samples_i[c*SAMPLE_W +: SAMPLE_W]),
      .cap_payload_i (in_frame),
      .cap_header_i  (hdr_accept),
      .payload_o     (samples_o[c*SAMPLE_W +: SAMPLE_W]),
      .height_o      (hdr_height_o[c*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: tb/frame_header_tracker_tb_top.sv
`timescale 1ns/1ps
module frame_header_tracker_tb_top;
  localparam int NCH = 4;
  localparam int SW  = 10;
  localparam int LEN = 256;
  localparam int LOW = 20;
  localparam int HIV = 800;

  // table: {header length, header amplitude, frame expected}
  localparam logic [14:0] VEC [6] = '{
    {4'd4, 10'd800, 1'b1},
    {4'd4, 10'd401, 1'b1},
    {4'd4, 10'd400, 1'b0},
    {4'd3, 10'd800, 1'b1},
    {4'd6, 10'd900, 1'b1},
    {4'd4, 10'd200, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [SW-1:0]     thresh;
  logic [3:0]        hdr_len;
  logic [NCH*SW-1:0] smp;
  logic              locked, fstart, valid;
  logic [7:0]        idx;
  logic [NCH*SW-1:0] sout, hgt;
  int                checks = 0;
  int                errors = 0;

  always #5 clk = ~clk;

  frame_header_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .thresh_i(thresh), .hdr_len_i(hdr_len),
    .samples_i(smp), .locked_o(locked), .frame_start_o(fstart),
    .sample_valid_o(valid), .sample_index_o(idx), .samples_o(sout),
    .hdr_height_o(hgt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_all(input int base, input int step);
    for (int k = 0; k < NCH; k++) smp[k*SW +: SW] = SW'((base + k*step) % 1024);
    @(posedge clk); #1;
  endtask

  task automatic lo(); put_all(LOW, 0); endtask
  task automatic hi(); put_all(HIV, 0); endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    smp = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (4) lo();
  endtask

  task automatic lock_up();
    for (int m = 0; m < 3; m++) begin
      hi(); hi(); lo();
      if (m == 1) check(locked == 1'b0, "R2 not yet locked", locked, 0);
      if (m < 2) repeat (67) lo();
    end
    check(locked == 1'b1, "R2 locked after three", locked, 1);
  endtask

  task automatic run_frame(input int hl, input int amp, input bit trailer);
    int bad_seq = 0, bad_dat = 0, bad_lck = 0;
    repeat (10) lo();
    for (int j = 0; j < hl; j++) put_all(amp, 10);
    check(hgt[SW-1:0] == SW'(amp), "R8 height ch0", hgt[SW-1:0], amp);
    check(hgt[(NCH-1)*SW +: SW] == SW'(amp + 10*(NCH-1)), "R8 height last ch",
          hgt[(NCH-1)*SW +: SW], amp + 10*(NCH-1));
    for (int i = 0; i < LEN; i++) begin
      put_all(i*3, 7);
      if (!valid || idx != 8'(i) || fstart != (i == 0)) bad_seq++;
      if (sout[SW-1:0] != SW'((i*3) % 1024) ||
          sout[(NCH-1)*SW +: SW] != SW'((i*3 + 7*(NCH-1)) % 1024)) bad_dat++;
      if (!locked) bad_lck++;
    end
    check(bad_seq == 0, "R6 strobe and index run", bad_seq, 0);
    check(bad_dat == 0, "R7 all channels on master timing", bad_dat, 0);
    check(bad_lck == 0, "R9 lock frozen in frame", bad_lck, 0);
    lo();
    check(valid == 1'b0, "R6 strobe ends after last", valid, 0);
    check(hgt[SW-1:0] == SW'(amp), "R8 height held", hgt[SW-1:0], amp);
    if (trailer) begin
      hi(); hi(); lo();
      check(locked == 1'b1, "R10 trailer keeps lock", locked, 1);
      repeat (67) lo(); hi(); hi(); lo();
      check(locked == 1'b1, "R10 period re-anchored", locked, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    thresh = SW'(400);
    hdr_len = 4'd4;
    do_reset();
    // R11
    check(locked == 1'b0 && valid == 1'b0 && fstart == 1'b0, "R11 reset state",
          {locked, valid, fstart}, 0);

    // table walk: R1 threshold, R5 header length, R6..R10 frame
    for (int e = 0; e < 6; e++) begin
      int hl, amp;
      bit exp_f;
      hl = int'(VEC[e][14:11]);
      amp = int'(VEC[e][10:1]);
      exp_f = VEC[e][0];
      hdr_len = 4'(hl);
      do_reset();
      lock_up();
      if (exp_f) begin
        run_frame(hl, amp, 1'b1);
      end else begin
        repeat (10) lo();
        for (int j = 0; j < hl; j++) put_all(amp, 10);
        lo();
        check(valid == 1'b0, "R1 at or below threshold is low", valid, 0);
        check(locked == 1'b1, "R1 lock kept", locked, 1);
      end
    end

    // R5 header while unlocked is ignored
    hdr_len = 4'd4;
    do_reset();
    hi(); hi(); lo(); repeat (67) lo(); hi(); hi(); lo();
    repeat (10) lo();
    repeat (4) hi();
    lo();
    check(valid == 1'b0, "R5 unlocked header ignored", valid, 0);

    // R3 missing marker
    do_reset();
    lock_up();
    repeat (69) lo();
    check(locked == 1'b1, "R3 lock held until due", locked, 1);
    lo();
    check(locked == 1'b0, "R3 missing marker drops lock", locked, 0);

    // R4 misplaced marker restarts chain
    do_reset();
    lock_up();
    repeat (30) lo(); hi(); hi(); lo();
    check(locked == 1'b0, "R4 early marker drops lock", locked, 0);
    repeat (67) lo(); hi(); hi(); lo();
    check(locked == 1'b0, "R4 second of new chain", locked, 0);
    repeat (67) lo(); hi(); hi(); lo();
    check(locked == 1'b1, "R4 relocked on new chain", locked, 1);

    // R10 no trailer after frame
    do_reset();
    lock_up();
    run_frame(4, 700, 1'b0);
    repeat (68) lo();
    check(locked == 1'b1, "R10 waits for trailer", locked, 1);
    lo();
    check(locked == 1'b0, "R10 absent trailer drops lock", locked, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule